// File: doc/BRIEF.md
# Downstream Port Link Event Controller

This block decides what one downstream port of a switch does whenever its link changes state. A raw link-status level is brought into the clock domain through a two-stage synchronizer. Edges of the synchronized level then start the port's link-event policy. When the link drops, the port's own queued TLPs are drained and the end of the drain is reported. Traffic that other ports send towards the dead port is answered with an Unsupported Request indication instead of being forwarded. When the link returns, the port offers flow-control credits that match its ingress buffer capacity. It also requests a slot power limit message. The credit offer and the message request each use a valid/ready handshake.

Configuration access to the port's bridge function never stops. Reads and writes complete whatever the link is doing, including writes that ask for retraining or a secondary bus reset. The slot power value written through configuration is kept across every link event, and so is the lane reversal setting captured at the start of training. Queued TLPs are modelled as an occupancy count. Descriptors and messages are abstract strobes.

Top module: `link_event_ctl`

## Requirements
- R1: A falling edge of the synchronized link level starts a flush. The queue count drops by one per cycle until it reaches zero. flushDone is then high for exactly one cycle. From the raw input going low, the pulse arrives within QDEPTH+4 cycles.
- R2: When egTlpValid is high while linkUp is 0, egTlpUr is 1 and egTlpFwd is 0. While linkUp is 1, egTlpFwd is 1 and egTlpUr is 0.
- R3: Every configuration request (cfgValid) gives cfgCplValid one cycle later, whether the link is up, down or being flushed. A read (cfgWe=0) returns the stored slot power value on cfgCplData.
- R4: A rising edge of the synchronized link raises credValid with credAmount equal to INGRESS_CREDITS. credValid stays high until a cycle with credReady high.
- R5: A rising edge of the synchronized link also requests a slot power limit message. pwrMsgValid carries the stored value on pwrMsgValue and stays high until pwrMsgReady is seen.
- R6: A configuration write with cfgSlotCap=1 stores cfgWrData as the slot power value. It requests a power limit message only when linkUp is 1. While the link is down it requests none.
- R7: A configuration write with cfgRetrain=1 pulses retrainReq for one cycle, one cycle after the request. Its completion is always returned, even during a flush.
- R8: laneRevCfg is captured only on a trainStart pulse. With reversal captured and linkX2=1, lane0Phys=1 and lane1Phys=0. Without reversal, lane0Phys=0 and lane1Phys=1. With linkX2=0, lane0Phys=0.
- R9: Link down and link up events leave the stored slot power value and the captured lane reversal unchanged.
- R10: When a credit offer and a power message are pending together, credValid is shown first. pwrMsgValid stays 0 until the credit offer is accepted.
- R11: rxEnq increments the queue count only while linkUp is 1, no flush is running and the count is below QDEPTH. rxDeq decrements a non-zero count. A raw link change appears on linkUp two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUpRaw | input | 1 | Asynchronous link-status level |
| trainStart | input | 1 | Pulse at the start of link training |
| laneRevCfg | input | 1 | Lane reversal setting |
| linkX2 | input | 1 | 1 = two-lane link, 0 = one lane |
| rxEnq | input | 1 | TLP from this port queued |
| rxDeq | input | 1 | Queued TLP of this port forwarded |
| egTlpValid | input | 1 | TLP from another port targets this port |
| cfgValid | input | 1 | Configuration request |
| cfgWe | input | 1 | 1 = write, 0 = read |
| cfgSlotCap | input | 1 | Write targets the slot capability register |
| cfgRetrain | input | 1 | Write asks for retrain or secondary bus reset |
| cfgWrData | input | PWR_W | Write data (slot power value) |
| credReady | input | 1 | Credit offer accepted |
| pwrMsgReady | input | 1 | Power message accepted |
| linkUp | output | 1 | Synchronized link level |
| qCount | output | CNT_W | TLPs of this port still queued |
| flushDone | output | 1 | One-cycle pulse at the end of a flush |
| egTlpFwd | output | 1 | Targeted TLP forwarded |
| egTlpUr | output | 1 | Targeted TLP marked Unsupported Request |
| cfgCplValid | output | 1 | Configuration completion |
| cfgCplData | output | PWR_W | Read completion data |
| retrainReq | output | 1 | Retrain or secondary reset request pulse |
| credValid | output | 1 | Credit offer pending |
| credAmount | output | CRED_W | Credits offered |
| pwrMsgValid | output | 1 | Slot power limit message request |
| pwrMsgValue | output | PWR_W | Power value carried by the message |
| lane0Phys | output | 1 | Physical lane carrying logical lane 0 |
| lane1Phys | output | 1 | Physical lane carrying logical lane 1 |

## Verification
On a link-up edge, the credit offer and the power message request both become pending in the same cycle. To provoke this, the bench raises the link while both ready inputs are held low for several cycles. It expects credValid to be high and pwrMsgValid to be low in every one of those cycles. Only after the credit handshake may the message appear, carrying the value written earlier while the link was down. A second collision is tested by issuing a retraining configuration write part-way through a flush. The bench checks that the completion and the retrain pulse come out on time while the drain continues to its done pulse.

// File: rtl/link_event_ctl_pkg.sv
package link_event_ctl_pkg;
  typedef struct packed {
    logic linkRise;
    logic linkFall;
    logic flushStep;
  } strb_t;

  typedef enum logic {ST_IDLE, ST_FLUSH} ctl_state_t;
endpackage

// File: rtl/link_event_ctl_ctrl.sv
module link_event_ctl_ctrl
  import link_event_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  linkUpRaw,
  input  logic  qEmpty,
  output strb_t strb,
  output logic  linkUp,
  output logic  flushDone
);
  logic [1:0] syncQ;
  logic       prevUp;
  ctl_state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 2'b00;
      prevUp <= 1'b0;
      state  <= ST_IDLE;
    end else begin
      syncQ  <= {syncQ[0], linkUpRaw};
      prevUp <= syncQ[1];
      state  <= stateNxt;
    end
  end

  assign linkUp = syncQ[1];

  always_comb begin
    strb.linkRise  = syncQ[1] & ~prevUp;
    strb.linkFall  = ~syncQ[1] & prevUp;
    strb.flushStep = 1'b0;
    flushDone      = 1'b0;
    stateNxt       = state;
    case (state)
      ST_IDLE: if (strb.linkFall) stateNxt = ST_FLUSH;
      ST_FLUSH: begin
        strb.flushStep = 1'b1;
        if (qEmpty) begin
          flushDone = 1'b1;
          stateNxt  = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/link_event_ctl_dpath.sv
module link_event_ctl_dpath
  import link_event_ctl_pkg::*;
#(
  parameter int QDEPTH          = 16,
  parameter int INGRESS_CREDITS = 32,
  parameter int CRED_W          = 8,
  parameter int PWR_W           = 8,
  localparam int CNT_W          = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic              linkUp,
  input  logic              rxEnq,
  input  logic              rxDeq,
  input  logic              egTlpValid,
  input  logic              cfgValid,
  input  logic              cfgWe,
  input  logic              cfgSlotCap,
  input  logic              cfgRetrain,
  input  logic [PWR_W-1:0]  cfgWrData,
  input  logic              trainStart,
  input  logic              laneRevCfg,
  input  logic              linkX2,
  input  logic              credReady,
  input  logic              pwrMsgReady,
  output logic [CNT_W-1:0]  qCount,
  output logic              qEmpty,
  output logic              egTlpFwd,
  output logic              egTlpUr,
  output logic              cfgCplValid,
  output logic [PWR_W-1:0]  cfgCplData,
  output logic              retrainReq,
  output logic              credValid,
  output logic [CRED_W-1:0] credAmount,
  output logic              pwrMsgValid,
  output logic [PWR_W-1:0]  pwrMsgValue,
  output logic              lane0Phys,
  output logic              lane1Phys
);
  localparam logic [CNT_W-1:0] Q_FULL = CNT_W'(QDEPTH);

  logic             credPend, msgPend, laneRev;
  logic [PWR_W-1:0] slotPwr;
  logic             doInc, doDec, slotWr;

  assign qEmpty = (qCount == '0);
  assign doInc  = rxEnq & linkUp & ~strb.flushStep & (qCount != Q_FULL);
  assign doDec  = (strb.flushStep | rxDeq) & ~qEmpty;
  assign slotWr = cfgValid & cfgWe & cfgSlotCap;

  always_ff @(posedge clk) begin
    if (!rstN) qCount <= '0;
    else if (doInc && !doDec) qCount <= qCount + 1'b1;
    else if (doDec && !doInc) qCount <= qCount - 1'b1;
  end

  assign egTlpFwd = egTlpValid & linkUp;
  assign egTlpUr  = egTlpValid & ~linkUp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCplValid <= 1'b0;
      cfgCplData  <= '0;
      retrainReq  <= 1'b0;
      slotPwr     <= '0;
      laneRev     <= 1'b0;
    end else begin
      cfgCplValid <= cfgValid;
      cfgCplData  <= (cfgValid && !cfgWe) ? slotPwr : '0;
      retrainReq  <= cfgValid & cfgWe & cfgRetrain;
      if (slotWr) slotPwr <= cfgWrData;
      if (trainStart) laneRev <= laneRevCfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      credPend <= 1'b0;
      msgPend  <= 1'b0;
    end else begin
      if (strb.linkFall) credPend <= 1'b0;
      else if (strb.linkRise) credPend <= 1'b1;
      else if (credValid && credReady) credPend <= 1'b0;

      if (strb.linkFall) msgPend <= 1'b0;
      else if (strb.linkRise || (slotWr && linkUp)) msgPend <= 1'b1;
      else if (pwrMsgValid && pwrMsgReady) msgPend <= 1'b0;
    end
  end

  assign credValid   = credPend;
  assign credAmount  = CRED_W'(INGRESS_CREDITS);
  assign pwrMsgValid = msgPend & ~credPend;
  assign pwrMsgValue = slotPwr;
  assign lane0Phys   = laneRev & linkX2;
  assign lane1Phys   = ~(laneRev & linkX2);
endmodule

// File: rtl/link_event_ctl.sv
module link_event_ctl
  import link_event_ctl_pkg::*;
#(
  parameter int QDEPTH          = 16,
  parameter int INGRESS_CREDITS = 32,
  parameter int CRED_W          = 8,
  parameter int PWR_W           = 8,
  localparam int CNT_W          = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUpRaw,
  input  logic              trainStart,
  input  logic              laneRevCfg,
  input  logic              linkX2,
  input  logic              rxEnq,
  input  logic              rxDeq,
  input  logic              egTlpValid,
  input  logic              cfgValid,
  input  logic              cfgWe,
  input  logic              cfgSlotCap,
  input  logic              cfgRetrain,
  input  logic [PWR_W-1:0]  cfgWrData,
  input  logic              credReady,
  input  logic              pwrMsgReady,
  output logic              linkUp,
  output logic [CNT_W-1:0]  qCount,
  output logic              flushDone,
  output logic              egTlpFwd,
  output logic              egTlpUr,
  output logic              cfgCplValid,
  output logic [PWR_W-1:0]  cfgCplData,
  output logic              retrainReq,
  output logic              credValid,
  output logic [CRED_W-1:0] credAmount,
  output logic              pwrMsgValid,
  output logic [PWR_W-1:0]  pwrMsgValue,
  output logic              lane0Phys,
  output logic              lane1Phys
);
  strb_t strb;
  logic  qEmpty;

  link_event_ctl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .linkUpRaw(linkUpRaw), .qEmpty(qEmpty),
    .strb(strb), .linkUp(linkUp), .flushDone(flushDone)
  );

  link_event_ctl_dpath #(
    .QDEPTH(QDEPTH), .INGRESS_CREDITS(INGRESS_CREDITS),
    .CRED_W(CRED_W), .PWR_W(PWR_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .linkUp(linkUp),
    .rxEnq(rxEnq), .rxDeq(rxDeq), .egTlpValid(egTlpValid),
    .cfgValid(cfgValid), .cfgWe(cfgWe), .cfgSlotCap(cfgSlotCap),
    .cfgRetrain(cfgRetrain), .cfgWrData(cfgWrData),
    .trainStart(trainStart), .laneRevCfg(laneRevCfg), .linkX2(linkX2),
    .credReady(credReady), .pwrMsgReady(pwrMsgReady),
    .qCount(qCount), .qEmpty(qEmpty), .egTlpFwd(egTlpFwd), .egTlpUr(egTlpUr),
    .cfgCplValid(cfgCplValid), .cfgCplData(cfgCplData), .retrainReq(retrainReq),
    .credValid(credValid), .credAmount(credAmount),
    .pwrMsgValid(pwrMsgValid), .pwrMsgValue(pwrMsgValue),
    .lane0Phys(lane0Phys), .lane1Phys(lane1Phys)
  );
endmodule

// File: rtl/link_event_ctl_chk.sv
module link_event_ctl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkUp,
  input logic [CNT_W-1:0] qCount,
  input logic             flushDone,
  input logic             egTlpFwd,
  input logic             egTlpUr,
  input logic             cfgValid,
  input logic             cfgWe,
  input logic             cfgRetrain,
  input logic             cfgCplValid,
  input logic             retrainReq,
  input logic             credValid,
  input logic             credReady,
  input logic             pwrMsgValid,
  input logic             pwrMsgReady
);
  // R1
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> (qCount == '0));

  // R1
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  // R2
  ur_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(egTlpFwd && egTlpUr));

  // R3
  cfg_cpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgCplValid);

  // R4
  cred_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (credValid && !credReady && linkUp) |=> credValid);

  // R5
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMsgValid && !pwrMsgReady && linkUp) |=> pwrMsgValid);

  // R7
  retrain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && cfgWe && cfgRetrain) |=> retrainReq);

  // R10
  cred_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    credValid |-> !pwrMsgValid);
endmodule

bind link_event_ctl link_event_ctl_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/link_event_ctl_tb_top.sv
`timescale 1ns/1ps
module link_event_ctl_tb_top;
  localparam int QDEPTH = 16;
  localparam int CREDS  = 32;
  localparam int CNT_W  = $clog2(QDEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkUpRaw = 0, trainStart = 0, laneRevCfg = 0, linkX2 = 0;
  logic rxEnq = 0, rxDeq = 0, egTlpValid = 0;
  logic cfgValid = 0, cfgWe = 0, cfgSlotCap = 0, cfgRetrain = 0;
  logic [7:0] cfgWrData = '0;
  logic credReady = 0, pwrMsgReady = 0;
  logic linkUp, flushDone, egTlpFwd, egTlpUr, cfgCplValid, retrainReq;
  logic credValid, pwrMsgValid, lane0Phys, lane1Phys;
  logic [CNT_W-1:0] qCount;
  logic [7:0] cfgCplData, credAmount, pwrMsgValue;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_event_ctl #(.QDEPTH(QDEPTH), .INGRESS_CREDITS(CREDS)) dut_i (.*);

  // {rxEnq, rxDeq, expected qCount}
  localparam logic [6:0] QVEC [7] = '{
    {1'b1, 1'b0, 5'd1}, {1'b1, 1'b0, 5'd2}, {1'b1, 1'b1, 5'd2},
    {1'b0, 1'b1, 5'd1}, {1'b1, 1'b0, 5'd2}, {1'b1, 1'b0, 5'd3},
    {1'b0, 1'b0, 5'd3}};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic cfgReq(logic we, logic slot, logic rt, logic [7:0] d);
    cfgValid = 1; cfgWe = we; cfgSlotCap = slot; cfgRetrain = rt; cfgWrData = d;
    tick();
    cfgValid = 0; cfgWe = 0; cfgSlotCap = 0; cfgRetrain = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    int got;
    repeat (3) tick();
    rstN = 1;
    tick();
    // reset state
    chk("R11 reset linkUp", linkUp, 0);
    chk("R4 reset credValid", credValid, 0);
    chk("R5 reset pwrMsgValid", pwrMsgValid, 0);
    chk("R1 reset qCount", qCount, 0);
    chk("R8 reset lane1Phys", lane1Phys, 1);

    // link down: UR, config service, no message
    egTlpValid = 1; #1;
    chk("R2 down ur", egTlpUr, 1);
    chk("R2 down fwd", egTlpFwd, 0);
    egTlpValid = 0;
    cfgReq(1, 1, 0, 8'h5A);
    chk("R3 cpl while down", cfgCplValid, 1);
    tick();
    chk("R6 no msg while down", pwrMsgValid, 0);
    cfgReq(0, 0, 0, 8'h00);
    chk("R3 read data", cfgCplData, 8'h5A);
    rxEnq = 1; tick(); rxEnq = 0;
    chk("R11 enq ignored while down", qCount, 0);

    // lane reversal capture
    laneRevCfg = 1; linkX2 = 1; trainStart = 1;
    tick();
    trainStart = 0; laneRevCfg = 0;
    chk("R8 rev lane0", lane0Phys, 1);
    chk("R8 rev lane1", lane1Phys, 0);
    tick();
    chk("R8 held without trainStart", lane0Phys, 1);

    // link up: credit first, then message (same-cycle collision)
    linkUpRaw = 1;
    tick();
    chk("R11 sync not yet", linkUp, 0);
    tick();
    chk("R11 sync two cycles", linkUp, 1);
    tick();
    chk("R4 cred on rise", credValid, 1);
    chk("R4 cred amount", credAmount, CREDS);
    chk("R10 msg held behind cred", pwrMsgValid, 0);
    tick();
    chk("R4 cred held", credValid, 1);
    chk("R10 msg still held", pwrMsgValid, 0);
    credReady = 1; tick(); credReady = 0;
    chk("R4 cred cleared", credValid, 0);
    chk("R5 msg after cred", pwrMsgValid, 1);
    chk("R9 msg value kept", pwrMsgValue, 8'h5A);
    tick();
    chk("R5 msg held", pwrMsgValid, 1);
    pwrMsgReady = 1; tick(); pwrMsgReady = 0;
    chk("R5 msg accepted", pwrMsgValid, 0);

    egTlpValid = 1; #1;
    chk("R2 up fwd", egTlpFwd, 1);
    chk("R2 up ur", egTlpUr, 0);
    egTlpValid = 0;

    // queue vectors
    foreach (QVEC[i]) begin
      rxEnq = QVEC[i][6]; rxDeq = QVEC[i][5];
      tick();
      chk($sformatf("R11 vector %0d", i), qCount, QVEC[i][4:0]);
    end
    rxEnq = 1; rxDeq = 0;
    for (int i = 0; i < 16; i++) tick();
    rxEnq = 0;
    chk("R11 saturate at depth", qCount, QDEPTH);

    // slot write while up
    cfgReq(1, 1, 0, 8'h33);
    chk("R6 msg on slot write", pwrMsgValid, 1);
    chk("R6 new value", pwrMsgValue, 8'h33);
    pwrMsgReady = 1; tick(); pwrMsgReady = 0;

    cfgReq(1, 0, 1, 8'h00);
    chk("R7 retrain pulse", retrainReq, 1);
    chk("R7 retrain cpl", cfgCplValid, 1);
    tick();
    chk("R7 pulse ends", retrainReq, 0);

    // link down flush with a retraining write in the middle
    linkUpRaw = 0;
    got = -1;
    for (int i = 1; i <= 40; i++) begin
      if (i == 6) cfgReq(1, 0, 1, 8'h00);
      else tick();
      if (i == 6) begin
        chk("R7 cpl during flush", cfgCplValid, 1);
        chk("R7 pulse during flush", retrainReq, 1);
      end
      if (flushDone && got < 0) got = i;
    end
    chk("R1 flushDone seen", (got > 0) ? 1 : 0, 1);
    chk("R1 flush bound", (got > 0 && got <= QDEPTH + 4) ? 1 : 0, 1);
    chk("R1 queue empty", qCount, 0);
    chk("R1 done is a pulse", flushDone, 0);
    chk("R4 cred idle when down", credValid, 0);
    egTlpValid = 1; #1;
    chk("R2 ur after flush", egTlpUr, 1);
    egTlpValid = 0;

    // link back up: settings persist
    linkUpRaw = 1;
    repeat (3) tick();
    chk("R4 cred again", credValid, 1);
    credReady = 1; tick(); credReady = 0;
    chk("R9 slot value kept", pwrMsgValue, 8'h33);
    chk("R5 msg again", pwrMsgValid, 1);
    chk("R9 lane rev kept", lane0Phys, 1);
    pwrMsgReady = 1; tick(); pwrMsgReady = 0;

    linkX2 = 0; #1;
    chk("R8 x1 lane0", lane0Phys, 0);

    finished = 1;
    summary();
  end
endmodule